// File: doc/BRIEF.md
# Half-word settings bus bridge

The bridge sits on a 16-bit Wishbone slave port and drives a write-only settings bus of 64 registers, each 32 bits wide. Software writes a register as two 16-bit half-words at the register's byte offset. The half-word with byte-offset bits `[1:0] = 00` is the low half, and the bridge holds it. The half-word with bits `[1:0] = 10` is the high half. When the high half arrives, the bridge joins it to the held low half. It then drives one single-cycle strobe that carries the register index and the full 32-bit word. Downstream consumers watch the strobe and pick out their own index.

The bridge decodes its own window from the upper address bits. Register n sits at byte offset 4*n from the window base. Reads return zero and are acknowledged. Three indices have side outputs:
- index 61 pulses a receive-FIFO clear for one cycle;
- index 62 pulses a transmit-FIFO clear for one cycle;
- index 63 raises a global-reset output for several cycles. It does not reset the bridge itself.

The settings strobe has no ready input, so consumers cannot stall it and must take every strobe they decode. Back-pressure toward software comes only from the Wishbone acknowledge. The bridge accepts a new access only after the previous one has been acknowledged.

Top module: `setbus_bridge`

## Requirements
- R1: During and after reset, `wb_ack_o`, `set_stb_o`, `clr_rx_o`, `clr_tx_o` and `gres_o` are low, and the held low half is zero.
- R2: A selected write with address bit 1 = 0 stores `wb_dat_i` as the held low half and produces no strobe.
- R3: A selected write with address bit 1 = 1 sets `set_stb_o` high for exactly one cycle. That cycle is the one following the clock edge that accepts the write. In that cycle `set_data_o` = {write data, held low half} and `set_addr_o` = address bits [7:2], zero-extended to 8 bits.
- R4: A high-half write that has no new low-half write before it reuses the most recently held low half.
- R5: The bridge accepts a selected access on a clock edge when it is idle and `wb_cyc_i`/`wb_stb_i` are high. `wb_ack_o` is high for exactly one cycle, two cycles after the accepting edge, which is the cycle after the strobe cycle. Each request produces one transfer.
- R6: A selected read is acknowledged as in R5, returns `wb_dat_o` = 0, produces no strobe and leaves the held low half unchanged.
- R7: An access whose address bits [10:8] differ from the window base (default 0x400) gets no acknowledge and no strobe, and leaves the held low half unchanged.
- R8: A strobe to index 63 raises `gres_o` in the following cycle and holds it for `RST_LEN` (default 4) consecutive cycles. The bridge keeps accepting accesses while `gres_o` is high.
- R9: `clr_rx_o` is high only in the strobe cycle of index 61, and `clr_tx_o` only in the strobe cycle of index 62.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle active |
| wb_stb_i | input | 1 | Access request |
| wb_we_i | input | 1 | 1 = write |
| wb_adr_i | input | 11 | Byte address |
| wb_dat_i | input | 16 | Write data |
| wb_dat_o | output | 16 | Read data, always zero |
| wb_ack_o | output | 1 | Access acknowledge |
| set_stb_o | output | 1 | Settings strobe, one cycle |
| set_addr_o | output | 8 | Register index carried by the strobe |
| set_data_o | output | 32 | 32-bit register value carried by the strobe |
| clr_rx_o | output | 1 | Receive-FIFO clear pulse |
| clr_tx_o | output | 1 | Transmit-FIFO clear pulse |
| gres_o | output | 1 | Global-reset pulse |

## Verification
The assertions check four things on every cycle:
- the strobe never lasts more than one cycle and only follows an accepted write;
- the acknowledge is one cycle wide and follows every strobe;
- the FIFO-clear pulses occur only together with a strobe;
- a strobe to index 63 is followed by the global-reset output.

Only the bench's scenarios can show that the data carried by the strobe pairs the correct low half with the correct high half. The same holds for:
- reads and out-of-window writes leaving the held half untouched;
- the global-reset pulse having exactly the configured length.

These follow from a behavioural model that the bench compares with the outputs on every cycle.

// File: rtl/setbus_pkg.sv
package setbus_pkg;
  // Handshake phase of one bus access
  typedef enum logic [1:0] {
    BR_IDLE = 2'd0,
    BR_HOLD = 2'd1,
    BR_ACK  = 2'd2
  } br_state_t;
endpackage

// File: rtl/setbus_decode.sv
module setbus_decode #(
  parameter int unsigned ADDR_W   = 11,
  parameter int unsigned NREG     = 64,
  parameter int unsigned WIN_BASE = 'h400
) (
  input  logic [ADDR_W-1:0]         adr_i,
  output logic                      hit_o,
  output logic [$clog2(NREG)-1:0]   idx_o,
  output logic                      upper_o
);
  localparam int unsigned IDX_W = $clog2(NREG);
  localparam int unsigned WIN_LSB = IDX_W + 2;
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(WIN_BASE);

  logic unused_lsb;
  assign unused_lsb = adr_i[0];

  assign hit_o   = (adr_i[ADDR_W-1:WIN_LSB] == BASE_V[ADDR_W-1:WIN_LSB]);
  assign idx_o   = adr_i[WIN_LSB-1:2];
  assign upper_o = adr_i[1];
endmodule

// File: rtl/setbus_assemble.sv
module setbus_assemble #(
  parameter int unsigned IDX_W   = 6,
  parameter int unsigned HALF_W  = 16,
  parameter int unsigned SADDR_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  take_i,
  input  logic                  we_i,
  input  logic                  upper_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [HALF_W-1:0]     wdat_i,
  output logic                  stb_o,
  output logic [SADDR_W-1:0]    saddr_o,
  output logic [2*HALF_W-1:0]   sdata_o
);
  logic [HALF_W-1:0] low_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      low_q   <= '0;
      stb_o   <= 1'b0;
      saddr_o <= '0;
      sdata_o <= '0;
    end else begin
      stb_o <= 1'b0;
      if (take_i && we_i) begin
        if (upper_i) begin
          stb_o   <= 1'b1;
          saddr_o <= SADDR_W'(idx_i);
          sdata_o <= {wdat_i, low_q};
        end else begin
          low_q <= wdat_i;
        end
      end
    end
  end

  // R3: the strobe never stays high for two cycles
  p_stb_one_cycle_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    stb_o |=> !stb_o);
endmodule

// File: rtl/setbus_pulse.sv
module setbus_pulse #(
  parameter int unsigned LEN = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic fire_i,
  output logic pulse_o
);
  localparam int unsigned CNT_W = $clog2(LEN + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)                cnt_q <= '0;
    else if (fire_i)          cnt_q <= CNT_W'(LEN);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_o = (cnt_q != '0);

  // R8: a request always starts the pulse on the next cycle
  p_gres_start_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    fire_i |=> pulse_o);
endmodule

// File: rtl/setbus_bridge.sv
module setbus_bridge
  import setbus_pkg::*;
#(
  parameter int unsigned ADDR_W     = 11,
  parameter int unsigned HALF_W     = 16,
  parameter int unsigned NREG       = 64,
  parameter int unsigned SADDR_W    = 8,
  parameter int unsigned WIN_BASE   = 'h400,
  parameter int unsigned RST_LEN    = 4,
  parameter int unsigned REG_RX_CLR = 61,
  parameter int unsigned REG_TX_CLR = 62,
  parameter int unsigned REG_GRES   = 63
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  wb_cyc_i,
  input  logic                  wb_stb_i,
  input  logic                  wb_we_i,
  input  logic [ADDR_W-1:0]     wb_adr_i,
  input  logic [HALF_W-1:0]     wb_dat_i,
  output logic [HALF_W-1:0]     wb_dat_o,
  output logic                  wb_ack_o,
  output logic                  set_stb_o,
  output logic [SADDR_W-1:0]    set_addr_o,
  output logic [2*HALF_W-1:0]   set_data_o,
  output logic                  clr_rx_o,
  output logic                  clr_tx_o,
  output logic                  gres_o
);
  localparam int unsigned IDX_W = $clog2(NREG);

  br_state_t        state_q;
  logic             hit, upper, take;
  logic [IDX_W-1:0] idx;

  setbus_decode #(.ADDR_W(ADDR_W), .NREG(NREG), .WIN_BASE(WIN_BASE)) u_dec (
    .adr_i(wb_adr_i), .hit_o(hit), .idx_o(idx), .upper_o(upper)
  );

  assign take = (state_q == BR_IDLE) && wb_cyc_i && wb_stb_i && hit;

  always_ff @(posedge clk_i) begin
    if (rst_i) state_q <= BR_IDLE;
    else begin
      unique case (state_q)
        BR_IDLE: if (take) state_q <= BR_HOLD;
        BR_HOLD: state_q <= BR_ACK;
        default: state_q <= BR_IDLE;
      endcase
    end
  end

  assign wb_ack_o = (state_q == BR_ACK);
  assign wb_dat_o = '0;

  setbus_assemble #(.IDX_W(IDX_W), .HALF_W(HALF_W), .SADDR_W(SADDR_W)) u_asm (
    .clk_i(clk_i), .rst_i(rst_i), .take_i(take), .we_i(wb_we_i),
    .upper_i(upper), .idx_i(idx), .wdat_i(wb_dat_i),
    .stb_o(set_stb_o), .saddr_o(set_addr_o), .sdata_o(set_data_o)
  );

  assign clr_rx_o = set_stb_o && (set_addr_o == SADDR_W'(REG_RX_CLR));
  assign clr_tx_o = set_stb_o && (set_addr_o == SADDR_W'(REG_TX_CLR));

  logic gres_fire;
  assign gres_fire = set_stb_o && (set_addr_o == SADDR_W'(REG_GRES));

  setbus_pulse #(.LEN(RST_LEN)) u_gres (
    .clk_i(clk_i), .rst_i(rst_i), .fire_i(gres_fire), .pulse_o(gres_o)
  );

  // R5: every strobe is followed by the acknowledge of its access
  p_ack_after_stb_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    set_stb_o |=> wb_ack_o);
  // R5: acknowledge is one cycle wide
  p_ack_single_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    wb_ack_o |=> !wb_ack_o);
  // R6: a strobe only follows a write request
  p_stb_from_write_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    set_stb_o |-> $past(wb_we_i && wb_stb_i && wb_cyc_i));
  // R9: clear pulses only appear with a strobe
  p_clr_on_stb_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr_rx_o || clr_tx_o) |-> set_stb_o);
endmodule

// File: tb/tb_setbus_bridge.sv
module tb_setbus_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int RST_LEN = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [10:0] adr = '0;
  logic [15:0] wdat = '0;
  logic [15:0] rdat;
  logic ack, s_stb, clr_rx, clr_tx, gres;
  logic [7:0] s_addr;
  logic [31:0] s_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  setbus_bridge #(.RST_LEN(RST_LEN)) dut (
    .clk_i(clk), .rst_i(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(rdat), .wb_ack_o(ack),
    .set_stb_o(s_stb), .set_addr_o(s_addr), .set_data_o(s_data),
    .clr_rx_o(clr_rx), .clr_tx_o(clr_tx), .gres_o(gres)
  );

  int checks = 0, errors = 0, cycles = 0;
  int n_stb = 0, n_rx = 0, n_tx = 0, n_gres = 0;
  int last_addr = -1;
  longint last_data = -1;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Behavioural reference model, updated on each rising edge
  int m_phase = 0, m_low = 0, m_gcnt = 0, m_addr = 0;
  bit m_stb = 0, m_ack = 0;
  longint m_data = 0;
  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_low = 0; m_gcnt = 0; m_stb = 0; m_ack = 0;
    end else begin
      bit nstb;
      if (m_stb && m_addr == 63) m_gcnt = RST_LEN;
      else if (m_gcnt > 0) m_gcnt--;
      nstb = 0;
      if (m_phase == 0) begin
        if (cyc && stb && (int'(adr) / 256) == 4) begin
          m_phase = 1;
          if (we) begin
            if ((int'(adr) % 4) >= 2) begin
              nstb = 1;
              m_addr = (int'(adr) / 4) % 64;
              m_data = longint'(wdat) * 65536 + m_low;
            end else m_low = int'(wdat);
          end
        end
      end else if (m_phase == 1) m_phase = 2;
      else m_phase = 0;
      m_ack = (m_phase == 2);
      m_stb = nstb;
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk(s_stb == m_stb, "R3 strobe timing", s_stb, m_stb);
      if (m_stb) begin
        chk(int'(s_addr) == m_addr, "R3 strobe address", s_addr, m_addr);
        chk(longint'(s_data) == m_data, "R3/R4 strobe data", s_data, m_data);
      end
      chk(ack == m_ack, "R5 acknowledge", ack, m_ack);
      chk(rdat == 16'h0, "R6 read data", rdat, 0);
      chk(gres == (m_gcnt > 0), "R8 global reset", gres, m_gcnt > 0);
      chk(clr_rx == (m_stb && m_addr == 61), "R9 rx clear", clr_rx, 0);
      chk(clr_tx == (m_stb && m_addr == 62), "R9 tx clear", clr_tx, 0);
      if (s_stb) begin n_stb++; last_addr = int'(s_addr); last_data = longint'(s_data); end
      if (clr_rx) n_rx++;
      if (clr_tx) n_tx++;
      if (gres) n_gres++;
    end
  end

  task automatic access(input bit w, input int a, input int d, input bit exp_ack, input string tag);
    bit got;
    got = 0;
    @(negedge clk);
    cyc = 1; stb = 1; we = w; adr = 11'(a); wdat = 16'(d);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (ack) begin got = 1; break; end
    end
    cyc = 0; stb = 0; we = 0;
    chk(got == exp_ack, tag, got, exp_ack);
  endtask

  task automatic wr32(input int idx, input int lo, input int hi);
    access(1, 'h400 + 4*idx, lo, 1, "R5 low-half ack");
    access(1, 'h400 + 4*idx + 2, hi, 1, "R5 high-half ack");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!ack && !s_stb && !gres && !clr_rx && !clr_tx, "R1 outputs in reset", ack, 0);
    rst = 0;
    @(negedge clk);
    chk(!ack && !s_stb && !gres, "R1 outputs after reset", s_stb, 0);

    // R2: low half alone makes no strobe
    access(1, 'h414, 'h1234, 1, "R5 low ack");
    repeat (2) @(negedge clk);
    chk(n_stb == 0, "R2 no strobe on low half", n_stb, 0);
    access(1, 'h416, 'hABCD, 1, "R5 high ack");
    chk(last_addr == 5 && last_data == 'hABCD1234, "R3 assembled word", last_data, 'hABCD1234);

    // R4: high half reuses held low
    access(1, 'h41E, 'h00FF, 1, "R5 ack");
    chk(last_addr == 7 && last_data == 'h00FF1234, "R4 reuse low half", last_data, 'h00FF1234);

    // R6: read
    access(0, 'h420, 0, 1, "R6 read ack");
    access(0, 'h422, 0, 1, "R6 read ack high");
    chk(n_stb == 2, "R6 read makes no strobe", n_stb, 2);

    // R7: outside window
    access(1, 'h084, 'h5555, 0, "R7 no ack outside window");
    access(1, 'h50A, 'h6666, 0, "R7 no ack above window");
    chk(n_stb == 2, "R7 no strobe outside window", n_stb, 2);
    access(1, 'h40A, 'h0001, 1, "R5 ack");
    chk(last_addr == 2 && last_data == 'h00011234, "R7 low half untouched", last_data, 'h00011234);

    // R9: FIFO clears
    wr32(61, 1, 0);
    wr32(62, 1, 0);
    chk(n_rx == 1 && n_tx == 1, "R9 one pulse each", n_rx * 16 + n_tx, 'h11);

    // R8: global reset, boundary indices
    wr32(0, 'hBEEF, 'hDEAD);
    chk(last_addr == 0 && last_data == 'hDEADBEEF, "R3 index 0", last_data, 'hDEADBEEF);
    wr32(63, 'h0001, 'h0000);
    wr32(1, 'h2222, 'h3333);
    chk(last_addr == 1 && last_data == 'h33332222, "R8 bridge alive after reset pulse", last_data, 'h33332222);
    repeat (6) @(negedge clk);
    chk(n_gres == RST_LEN, "R8 reset pulse length", n_gres, RST_LEN);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule